// File: doc/BRIEF.md
# Parallel Pixel Task Dispatcher

This block sits between a coordinate mapper and a frame-buffer writer in a fractal renderer. Each work item pairs a point on the complex plane with the pixel address it belongs to. Items enter a task queue. Each one goes to the first free iteration core in a bank of parallel cores. The bank holds 16 cores by default.

A core can finish before a core that started earlier, because points that escape quickly take fewer cycles. For this reason every result keeps the pixel address of its task. Each core writes into a short result queue of its own. This lets a core start new work while the shared single-port memory is still busy with other writes. A round-robin drain merges the result queues into one write stream with a valid/ready handshake.

The iteration arithmetic is replaced by a stub core. The stub reports count = min(re XOR im, 1024), taking both coordinates as unsigned 16-bit values, and it needs count + 1 cycles to do so. This gives a deterministic, value-dependent latency that still exercises the escape path and the iteration-limit path.

Top module: `pixel_task_dispatcher`

## Requirements
- R1: While reset is held low, and on the first cycle after it is released, `taskReady` is 1 and `wrValid` is 0.
- R2: A task is accepted on each rising edge where `taskValid` and `taskReady` are both 1. The task queue holds 16 tasks. `taskReady` is 0 while the queue is full.
- R3: One task is issued per cycle at most. It goes to the lowest-numbered core that is idle and whose result queue is not full.
- R4: The reported `wrCount` is min(taskRe XOR taskIm, 1024), both taken as unsigned 16-bit values. A value of 1024 means the point did not escape within the iteration limit. `wrCount` is never above 1024.
- R5: On an idle block with `wrReady` held at 1, take a task accepted at edge 0 whose result is r. `wrValid` is 0 after edges 0 to r+1 and rises after edge r+2.
- R6: Every accepted task produces exactly one write. That write carries the task's own `taskAddr` as `wrAddr`.
- R7: Each result queue is 4 deep. With `wrReady` held at 0, the block accepts exactly 80 tasks (16 cores × 4 results, plus 16 queued tasks) and then holds `taskReady` at 0.
- R8: While `wrValid` is 1 and `wrReady` is 0, on the next cycle `wrValid` stays 1 and `wrAddr` and `wrCount` are unchanged.
- R9: The drain grants result queues in round-robin order by core index. Under `wrReady` = 1 it completes one write per cycle while any result is waiting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Synchronous reset, active low |
| taskValid | input | 1 | Task offered |
| taskReady | output | 1 | Task queue has space |
| taskRe | input | 16 | Real coordinate of the point |
| taskIm | input | 16 | Imaginary coordinate of the point |
| taskAddr | input | 20 | Pixel address of the point |
| wrValid | output | 1 | A result is offered to the memory writer |
| wrReady | input | 1 | Memory writer takes the result |
| wrAddr | output | 20 | Pixel address of the offered result |
| wrCount | output | 11 | Escape iteration, or 1024 if the point did not escape |

## Verification
A task accepted at edge 0 with result r is issued to a core at edge 1. Its result enters the core's result queue at edge r+2, so `wrValid` is due right after that edge. The bench counts that window edge by edge on falling edges and expects the output low through edge r+1 and high after edge r+2. All other results are due at times that depend on how busy the cores are. For these, the bench checks data rather than time: each write is matched on a falling edge against the expected count for its address, and the bench confirms that every address appears once. The queue-depth, stall-hold and round-robin checks work by stopping the write port and counting accepted tasks and successive write cycles.

// File: rtl/dispatch_pkg.sv
package dispatch_pkg;

  // Control-to-datapath strobes for one cycle.
  typedef struct packed {
    logic issue;  // pop the task queue head into the selected core
    logic drain;  // pop the selected result queue onto the write port
  } dispStrobe_t;

endpackage

// File: rtl/sync_fifo.sv
module sync_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         push,
  input  logic [W-1:0] pushData,
  input  logic         pop,
  output logic [W-1:0] popData,
  output logic         empty,
  output logic         full
);
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNTW = $clog2(DEPTH + 1);

  logic [W-1:0]    mem [DEPTH];
  logic [PW-1:0]   wrPtr, rdPtr;
  logic [CNTW-1:0] count;
  logic            doPush, doPop;

  assign empty   = (count == '0);
  assign full    = (count == CNTW'(DEPTH));
  assign doPush  = push && !full;
  assign doPop   = pop && !empty;
  assign popData = mem[rdPtr];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (doPush) wrPtr <= (wrPtr == PW'(DEPTH - 1)) ? '0 : wrPtr + 1'b1;
      if (doPop)  rdPtr <= (rdPtr == PW'(DEPTH - 1)) ? '0 : rdPtr + 1'b1;
      if (doPush && !doPop)      count <= count + 1'b1;
      else if (doPop && !doPush) count <= count - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= pushData;
  end
endmodule

// File: rtl/task_core_stub.sv
module task_core_stub #(
  parameter int CW       = 16,
  parameter int AW       = 20,
  parameter int MAX_ITER = 1024,
  parameter int IW       = $clog2(MAX_ITER + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          start,
  input  logic [CW-1:0] startRe,
  input  logic [CW-1:0] startIm,
  input  logic [AW-1:0] startAddr,
  output logic          busy,
  output logic          done,
  output logic [IW-1:0] resCount,
  output logic [AW-1:0] resAddr
);
  logic [IW-1:0] iter;
  logic [CW-1:0] escapeAt;

  // Stand-in for the iteration loop: the point "escapes" when the count
  // reaches re^im, or stops at the iteration limit.
  assign done     = busy && ((CW'(iter) == escapeAt) || (iter == IW'(MAX_ITER)));
  assign resCount = iter;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy <= 1'b0;
      iter <= '0;
    end else if (start) begin
      busy <= 1'b1;
      iter <= '0;
    end else if (done) begin
      busy <= 1'b0;
    end else if (busy) begin
      iter <= iter + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (start) begin
      escapeAt <= startRe ^ startIm;
      resAddr  <= startAddr;
    end
  end
endmodule

// File: rtl/dispatch_datapath.sv
module dispatch_datapath
  import dispatch_pkg::*;
#(
  parameter int NUM_CORES  = 16,
  parameter int TASK_DEPTH = 16,
  parameter int RES_DEPTH  = 4,
  parameter int CW         = 16,
  parameter int AW         = 20,
  parameter int MAX_ITER   = 1024,
  parameter int IW         = $clog2(MAX_ITER + 1),
  parameter int IDX_W      = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  dispStrobe_t          strb,
  input  logic [IDX_W-1:0]     issueCore,
  input  logic [IDX_W-1:0]     drainCore,
  input  logic                 taskValid,
  input  logic [CW-1:0]        taskRe,
  input  logic [CW-1:0]        taskIm,
  input  logic [AW-1:0]        taskAddr,
  output logic                 taskReady,
  output logic                 taskAvail,
  output logic [NUM_CORES-1:0] coreIdle,
  output logic [NUM_CORES-1:0] resFull,
  output logic [NUM_CORES-1:0] resAvail,
  output logic [AW-1:0]        wrAddr,
  output logic [IW-1:0]        wrCount
);
  localparam int TW = 2 * CW + AW;
  localparam int RW = AW + IW;

  logic [TW-1:0] taskHead;
  logic          taskFull, taskEmpty;
  logic [CW-1:0] headRe, headIm;
  logic [AW-1:0] headAddr;
  logic [RW-1:0] resHead [NUM_CORES];

  assign taskReady = !taskFull;
  assign taskAvail = !taskEmpty;
  assign {headRe, headIm, headAddr} = taskHead;

  sync_fifo #(.W(TW), .DEPTH(TASK_DEPTH)) u_taskQ (
    .clk(clk), .rstN(rstN),
    .push(taskValid), .pushData({taskRe, taskIm, taskAddr}),
    .pop(strb.issue), .popData(taskHead),
    .empty(taskEmpty), .full(taskFull)
  );

  for (genvar k = 0; k < NUM_CORES; k++) begin : g_lane
    logic          startK, popK, coreBusy, coreDone, resEmpty;
    logic [IW-1:0] coreCnt;
    logic [AW-1:0] coreAddr;

    assign startK      = strb.issue && (issueCore == IDX_W'(k));
    assign popK        = strb.drain && (drainCore == IDX_W'(k));
    assign coreIdle[k] = !coreBusy;
    assign resAvail[k] = !resEmpty;

    task_core_stub #(.CW(CW), .AW(AW), .MAX_ITER(MAX_ITER), .IW(IW)) u_core (
      .clk(clk), .rstN(rstN), .start(startK),
      .startRe(headRe), .startIm(headIm), .startAddr(headAddr),
      .busy(coreBusy), .done(coreDone), .resCount(coreCnt), .resAddr(coreAddr)
    );

    sync_fifo #(.W(RW), .DEPTH(RES_DEPTH)) u_resQ (
      .clk(clk), .rstN(rstN),
      .push(coreDone), .pushData({coreAddr, coreCnt}),
      .pop(popK), .popData(resHead[k]),
      .empty(resEmpty), .full(resFull[k])
    );
  end

  assign {wrAddr, wrCount} = resHead[drainCore];
endmodule

// File: rtl/dispatch_control.sv
module dispatch_control
  import dispatch_pkg::*;
#(
  parameter int NUM_CORES = 16,
  parameter int IDX_W     = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 taskAvail,
  input  logic [NUM_CORES-1:0] coreIdle,
  input  logic [NUM_CORES-1:0] resFull,
  input  logic [NUM_CORES-1:0] resAvail,
  input  logic                 wrReady,
  output dispStrobe_t          strb,
  output logic [IDX_W-1:0]     issueCore,
  output logic [IDX_W-1:0]     drainCore,
  output logic                 wrValid
);
  logic [NUM_CORES-1:0] freeVec;
  logic [IDX_W-1:0]     rrPtr, rrPick, lockIdx;
  logic                 locked;

  assign freeVec = coreIdle & ~resFull;

  // Lowest-numbered free core wins.
  always_comb begin : p_issuePick
    issueCore = '0;
    for (int i = NUM_CORES - 1; i >= 0; i--) begin
      if (freeVec[i]) issueCore = IDX_W'(i);
    end
  end

  // First non-empty result queue at or after the rotating pointer.
  always_comb begin : p_rrPick
    int  idx;
    logic found;
    rrPick = '0;
    found  = 1'b0;
    for (int i = 0; i < NUM_CORES; i++) begin
      idx = int'(rrPtr) + i;
      if (idx >= NUM_CORES) idx = idx - NUM_CORES;
      if (!found && resAvail[idx]) begin
        found  = 1'b1;
        rrPick = IDX_W'(idx);
      end
    end
  end

  assign wrValid    = |resAvail;
  assign drainCore  = locked ? lockIdx : rrPick;
  assign strb.issue = taskAvail && (|freeVec);
  assign strb.drain = wrValid && wrReady;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rrPtr  <= '0;
      locked <= 1'b0;
    end else begin
      if (strb.drain)
        rrPtr <= (drainCore == IDX_W'(NUM_CORES - 1)) ? '0 : drainCore + 1'b1;
      locked <= wrValid && !wrReady;
    end
  end

  always_ff @(posedge clk) begin
    lockIdx <= drainCore;
  end
endmodule

// File: rtl/pixel_task_dispatcher.sv
module pixel_task_dispatcher
  import dispatch_pkg::*;
#(
  parameter int NUM_CORES  = 16,
  parameter int TASK_DEPTH = 16,
  parameter int RES_DEPTH  = 4,
  parameter int CW         = 16,
  parameter int AW         = 20,
  parameter int MAX_ITER   = 1024,
  localparam int IW        = $clog2(MAX_ITER + 1),
  localparam int IDX_W     = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          taskValid,
  output logic          taskReady,
  input  logic [CW-1:0] taskRe,
  input  logic [CW-1:0] taskIm,
  input  logic [AW-1:0] taskAddr,
  output logic          wrValid,
  input  logic          wrReady,
  output logic [AW-1:0] wrAddr,
  output logic [IW-1:0] wrCount
);
  dispStrobe_t          strb;
  logic [IDX_W-1:0]     issueCore, drainCore;
  logic                 taskAvail;
  logic [NUM_CORES-1:0] coreIdle, resFull, resAvail;

  dispatch_control #(.NUM_CORES(NUM_CORES), .IDX_W(IDX_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .taskAvail(taskAvail),
    .coreIdle(coreIdle), .resFull(resFull), .resAvail(resAvail),
    .wrReady(wrReady), .strb(strb), .issueCore(issueCore),
    .drainCore(drainCore), .wrValid(wrValid)
  );

  dispatch_datapath #(
    .NUM_CORES(NUM_CORES), .TASK_DEPTH(TASK_DEPTH), .RES_DEPTH(RES_DEPTH),
    .CW(CW), .AW(AW), .MAX_ITER(MAX_ITER), .IW(IW), .IDX_W(IDX_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .issueCore(issueCore), .drainCore(drainCore),
    .taskValid(taskValid), .taskRe(taskRe), .taskIm(taskIm), .taskAddr(taskAddr),
    .taskReady(taskReady), .taskAvail(taskAvail),
    .coreIdle(coreIdle), .resFull(resFull), .resAvail(resAvail),
    .wrAddr(wrAddr), .wrCount(wrCount)
  );
endmodule

// File: rtl/dispatch_checker.sv
module dispatch_checker #(
  parameter int NUM_CORES = 16,
  parameter int AW        = 20,
  parameter int MAX_ITER  = 1024,
  parameter int IW        = $clog2(MAX_ITER + 1),
  parameter int IDX_W     = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 wrValid,
  input logic                 wrReady,
  input logic [AW-1:0]        wrAddr,
  input logic [IW-1:0]        wrCount,
  input logic                 issue,
  input logic [IDX_W-1:0]     issueCore,
  input logic [NUM_CORES-1:0] coreIdle,
  input logic [NUM_CORES-1:0] resFull
);
  logic [NUM_CORES-1:0] belowMask;
  assign belowMask = (NUM_CORES'(1) << issueCore) - NUM_CORES'(1);

  AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (wrValid && !wrReady) |=> (wrValid && $stable(wrAddr) && $stable(wrCount))); // R8

  AST_COUNT_LIMIT: assert property (@(posedge clk) disable iff (!rstN)
    wrValid |-> (int'(wrCount) <= MAX_ITER)); // R4

  AST_ISSUE_TO_FREE: assert property (@(posedge clk) disable iff (!rstN)
    issue |-> (coreIdle[issueCore] && !resFull[issueCore])); // R3

  AST_ISSUE_LOWEST: assert property (@(posedge clk) disable iff (!rstN)
    issue |-> ((coreIdle & ~resFull & belowMask) == '0)); // R3
endmodule

bind pixel_task_dispatcher dispatch_checker #(
  .NUM_CORES(NUM_CORES), .AW(AW), .MAX_ITER(MAX_ITER), .IW(IW), .IDX_W(IDX_W)
) u_chk (
  .clk(clk), .rstN(rstN), .wrValid(wrValid), .wrReady(wrReady),
  .wrAddr(wrAddr), .wrCount(wrCount), .issue(strb.issue),
  .issueCore(issueCore), .coreIdle(coreIdle), .resFull(resFull)
);

// File: tb/pixel_task_dispatcher_tb.sv
module pixel_task_dispatcher_tb;
  localparam int CW = 16, AW = 20, MAX_ITER = 1024, IW = 11, NA = 1024;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          rstN, taskValid, taskReady, wrValid, wrReady;
  logic [CW-1:0] taskRe, taskIm;
  logic [AW-1:0] taskAddr, wrAddr;
  logic [IW-1:0] wrCount;

  pixel_task_dispatcher u_dut (
    .clk(clk), .rstN(rstN), .taskValid(taskValid), .taskReady(taskReady),
    .taskRe(taskRe), .taskIm(taskIm), .taskAddr(taskAddr),
    .wrValid(wrValid), .wrReady(wrReady), .wrAddr(wrAddr), .wrCount(wrCount)
  );

  int checks = 0, fails = 0, cyc = 0, wrTotal = 0;
  bit finished = 1'b0;
  int expCount [NA];
  int seen     [NA];
  int logAddr  [NA];
  int logCyc   [NA];

  always @(posedge clk) cyc++;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int expIter(input int re, input int im);
    int v;
    v = (re ^ im) & 16'hFFFF;
    return (v >= MAX_ITER) ? MAX_ITER : v;
  endfunction

  // Write monitor: a handshake seen on the falling edge completes at the next rise.
  always @(negedge clk) begin : p_mon
    int a;
    if (rstN && wrValid && wrReady) begin
      a = int'(wrAddr);
      if (a >= NA || expCount[a] < 0) begin
        check(1'b0, "R6 unissued address", a, -1);
      end else begin
        check(seen[a] == 0, "R6 single write per address", seen[a] + 1, 1);
        check(int'(wrCount) == expCount[a], "R4 count for address", int'(wrCount), expCount[a]);
        seen[a]++;
      end
      if (wrTotal < NA) begin
        logAddr[wrTotal] = a;
        logCyc[wrTotal]  = cyc;
      end
      wrTotal++;
    end
  end

  // Called at posedge+1; returns at posedge+1 after the accepting edge.
  task automatic pushTask(input int addr, input int re, input int im);
    expCount[addr] = expIter(re, im);
    taskValid = 1'b1;
    taskAddr  = AW'(addr);
    taskRe    = CW'(re);
    taskIm    = CW'(im);
    @(negedge clk);
    while (!taskReady) @(negedge clk);
    @(posedge clk);
    #1 taskValid = 1'b0;
  endtask

  task automatic waitWrites(input int target, input string req);
    int guard;
    guard = 0;
    while (wrTotal < target && guard < 30000) begin
      @(posedge clk);
      guard++;
    end
    #1;
    check(wrTotal == target, req, wrTotal, target);
  endtask

  task automatic checkRange(input int base, input int n, input string req);
    int missing;
    missing = 0;
    for (int i = 0; i < n; i++) if (seen[base + i] != 1) missing++;
    check(missing == 0, req, missing, 0);
  endtask

  task automatic testReset();
    rstN = 1'b0; taskValid = 1'b0; wrReady = 1'b1;
    taskRe = '0; taskIm = '0; taskAddr = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(taskReady == 1'b1, "R1 taskReady in reset", taskReady, 1);
    check(wrValid == 1'b0, "R1 wrValid in reset", wrValid, 0);
    @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    check(taskReady == 1'b1, "R1 taskReady after reset", taskReady, 1);
    check(wrValid == 1'b0, "R1 wrValid after reset", wrValid, 0);
    @(posedge clk);
    #1;
  endtask

  // R5: result 5 on an idle block, wrValid due right after edge 7.
  task automatic testLatency();
    wrReady = 1'b1;
    pushTask(0, 5, 0);
    for (int j = 0; j <= 7; j++) begin
      @(negedge clk);
      if (j < 7) check(wrValid == 1'b0, "R5 wrValid early", wrValid, 0);
      else begin
        check(wrValid == 1'b1, "R5 wrValid on time", wrValid, 1);
        check(int'(wrAddr) == 0, "R6 address of latency task", int'(wrAddr), 0);
        check(int'(wrCount) == 5, "R5 count of latency task", int'(wrCount), 5);
      end
    end
    @(posedge clk);
    #1;
    waitWrites(1, "R5 latency task written");
  endtask

  // R4: escape boundary and the non-escape code 1024.
  task automatic testLimit();
    pushTask(10, 1023, 0);
    pushTask(11, 1024, 0);
    pushTask(12, 16'hFFFF, 0);
    pushTask(13, 16'h0F0F, 16'h0F0F);
    waitWrites(5, "R4 limit tasks drained");
    checkRange(10, 4, "R4 limit tasks each written once");
  endtask

  // R6: mixed latencies, out-of-order completion, irregular write stalls.
  task automatic testBurst();
    bit pushDone;
    pushDone = 1'b0;
    fork
      begin
        for (int i = 0; i < 150; i++)
          pushTask(100 + i, int'($urandom_range(0, 1100)), int'($urandom_range(0, 63)));
        pushDone = 1'b1;
      end
      begin
        while (!pushDone) begin
          @(posedge clk);
          #1 wrReady = ($urandom_range(0, 3) != 0);
        end
      end
    join
    wrReady = 1'b1;
    waitWrites(155, "R6 burst drained");
    checkRange(100, 150, "R6 burst each address written once");
  endtask

  // R7 depth limits under a stopped write port, then R8 hold.
  task automatic testFill();
    int accepted, a1, c1;
    accepted = 0;
    @(posedge clk);
    #1 wrReady = 1'b0;
    taskValid = 1'b1;
    taskAddr = AW'(300); taskRe = '0; taskIm = '0;
    repeat (300) begin
      @(negedge clk);
      if (taskReady) begin
        expCount[300 + accepted] = expIter(accepted % 8, 0);
        accepted++;
      end
      @(posedge clk);
      #1;
      taskAddr = AW'(300 + accepted);
      taskRe   = CW'(accepted % 8);
    end
    taskValid = 1'b0;
    check(accepted == 80, "R7 tasks accepted with port stopped", accepted, 80);
    @(negedge clk);
    check(taskReady == 1'b0, "R2 taskReady low when task queue full", taskReady, 0);
    check(wrValid == 1'b1, "R8 wrValid while stalled", wrValid, 1);
    a1 = int'(wrAddr); c1 = int'(wrCount);
    repeat (5) @(negedge clk);
    check(wrValid == 1'b1, "R8 wrValid held", wrValid, 1);
    check(int'(wrAddr) == a1, "R8 wrAddr held", int'(wrAddr), a1);
    check(int'(wrCount) == c1, "R8 wrCount held", int'(wrCount), c1);
    @(posedge clk);
    #1 wrReady = 1'b1;
    waitWrites(235, "R7 filled results drained");
    checkRange(300, 80, "R7 filled results each written once");
  endtask

  // R9 and R3: task i lands in core i; the drain rotates through core indices.
  task automatic testRoundRobin();
    int first, steps;
    @(posedge clk);
    #1 wrReady = 1'b0;
    for (int i = 0; i < 16; i++) pushTask(400 + i, 100, 0);
    repeat (200) @(posedge clk);
    #1;
    first = wrTotal;
    wrReady = 1'b1;
    waitWrites(251, "R9 round-robin results drained");
    steps = 0;
    for (int k = 0; k < 15; k++)
      if (((logAddr[first + k + 1] - logAddr[first + k] + 16) % 16) == 1) steps++;
    check(steps == 15, "R9 R3 writes rotate by core index", steps, 15);
    check(logCyc[first + 15] - logCyc[first] == 15, "R9 one write per cycle",
          logCyc[first + 15] - logCyc[first], 15);
    checkRange(400, 16, "R6 round-robin tasks each written once");
  endtask

  initial begin : p_main
    for (int i = 0; i < NA; i++) begin
      expCount[i] = -1;
      seen[i] = 0;
    end
    testReset();
    testLatency();
    testLimit();
    testBurst();
    testFill();
    testRoundRobin();
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin : p_watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual=%0d expected=%0d (cycles)", cyc, 150000);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule